// File: doc/BRIEF.md
# Shared-Bus Duplex Port Controller

This block is the control logic for one synchronous side of a two-way buffer. The side has a single 18-bit bidirectional data bus and two FIFOs behind it. The outbound FIFO takes words that arrive on the bus. The inbound FIFO supplies words that are driven back out on the same bus. An active-low port select and a direction select choose which of the two uses the bus has. A write enable and a read enable, both active high and both sampled on the rising edge of the free-running port clock, start the transfers.

The bus output enable comes straight from the two select pins and does not pass through any register. A host can therefore turn the bus around at any point in a cycle. When both enables are low, a select change never starts a transfer.

Towards each FIFO the port behaves as a stream endpoint. On the outbound side, `push_valid` is the valid and `ob_space` is the ready. A write that arrives while `ob_space` is low is dropped and is not held over, so the host has to try again. On the inbound side, `ib_avail` is the valid and `pop_take` marks the word as consumed. A pop is never issued without `ib_avail`. Both strobes are registered off the same clock edge that decided them.

Top module: `duplex_port_ctl`

## Requirements
- R1: `bus_oe` is 1 exactly when `sel_n`=0 and `dir_wr`=0, and it follows these two pins combinationally within the same cycle.
- R2: If a rising edge sees `sel_n`=0, `dir_wr`=1, `wr_en`=1 and `ob_space`=1, then `push_valid` is 1 for the following cycle and `push_data` holds the `bus_din` value sampled at that edge. Otherwise `push_valid` is 0 in the following cycle.
- R3: If a rising edge sees `sel_n`=0, `dir_wr`=0, `rd_en`=1 and `ib_avail`=1, then `pop_take` is 1 for the following cycle. Otherwise `pop_take` is 0 in the following cycle. In particular, a read request made while `ib_avail`=0 produces no pop.
- R4: An edge that sees `sel_n`=1 produces neither strobe, whatever the other inputs are.
- R5: `push_valid` and `pop_take` are never both 1 in the same cycle.
- R6: While `rst_n`=0 and in the first cycle after it, both strobes are 0 and `push_data` is 0.
- R7: With `wr_en`=0 and `rd_en`=0, any number of changes to `sel_n` and `dir_wr` within a cycle start no transfer, while `bus_oe` follows the selects.
- R8: `bus_dout` equals `ib_head`, the inbound FIFO's head word.
- R9: `push_data` keeps its value in every cycle in which `push_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running port clock; the rising edge is the sampling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Port select, active low |
| dir_wr | input | 1 | Direction: 1 = bus writes outbound FIFO, 0 = bus reads inbound FIFO |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Read enable, active high |
| ob_space | input | 1 | Outbound FIFO can accept a word (ready) |
| ib_avail | input | 1 | Inbound FIFO has a word at its head (valid) |
| bus_din | input | 18 | Value currently on the bus pads |
| ib_head | input | 18 | Inbound FIFO head word |
| bus_oe | output | 1 | Bus output enable for the pad drivers |
| bus_dout | output | 18 | Word presented to the pad drivers |
| push_valid | output | 1 | Registered write strobe to the outbound FIFO |
| push_data | output | 18 | Captured bus word for the outbound FIFO |
| pop_take | output | 1 | Registered read strobe to the inbound FIFO |

## Verification
The only state in the block is the strobe and capture registers. A wrong state there shows up at the ports one cycle after the deciding edge: a strobe that fires or stays silent against the select/enable/flag combination, or a `push_data` word that is stale or changes without a push. A decode fault in the output enable is combinational and is visible immediately, before any edge. The bench therefore sweeps every combination of the six control inputs. For each combination it checks the enable at once and the strobes and captured word one cycle later.

// File: rtl/duplex_port_pkg.sv
package duplex_port_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_WRITE = 2'd1,
    BUS_READ  = 2'd2
  } bus_mode_e;

  typedef struct packed {
    logic push;
    logic pop;
  } strobe_t;

  function automatic bus_mode_e mode_of(input logic sel_n, input logic dir_wr);
    if (sel_n)       return BUS_IDLE;
    else if (dir_wr) return BUS_WRITE;
    else             return BUS_READ;
  endfunction

endpackage

// File: rtl/port_mode_decode.sv
module port_mode_decode
  import duplex_port_pkg::*;
(
  input  logic      sel_n,
  input  logic      dir_wr,
  output bus_mode_e mode,
  output logic      oe
);
  always_comb begin
    mode = mode_of(sel_n, dir_wr);
    oe   = (mode == BUS_READ);
  end
endmodule

// File: rtl/xfer_qualify.sv
module xfer_qualify
  import duplex_port_pkg::*;
(
  input  bus_mode_e mode,
  input  logic      wr_en,
  input  logic      rd_en,
  input  logic      ob_space,
  input  logic      ib_avail,
  output strobe_t   fire
);
  always_comb begin
    fire.push = 1'b0;
    fire.pop  = 1'b0;
    unique case (mode)
      BUS_WRITE: fire.push = wr_en & ob_space;
      BUS_READ:  fire.pop  = rd_en & ib_avail;
      default:   ;
    endcase
  end
endmodule

// File: rtl/strobe_stage.sv
module strobe_stage
  import duplex_port_pkg::*;
#(
  parameter int W          = 18,
  parameter bit DATA_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      fire,
  input  logic [W-1:0] din,
  output strobe_t      q,
  output logic [W-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= fire;
  end

  generate
    if (DATA_RESET) begin : g_rst_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         data_q <= '0;
        else if (fire.push) data_q <= din;
      end
    end else begin : g_plain_data
      always_ff @(posedge clk) begin
        if (fire.push) data_q <= din;
      end
    end
  endgenerate
endmodule

// File: rtl/duplex_port_ctl.sv
module duplex_port_ctl
  import duplex_port_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         dir_wr,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic         ob_space,
  input  logic         ib_avail,
  input  logic [W-1:0] bus_din,
  input  logic [W-1:0] ib_head,
  output logic         bus_oe,
  output logic [W-1:0] bus_dout,
  output logic         push_valid,
  output logic [W-1:0] push_data,
  output logic         pop_take
);
  bus_mode_e mode;
  strobe_t   fire;
  strobe_t   stb_q;

  port_mode_decode u_dec (
    .sel_n  (sel_n),
    .dir_wr (dir_wr),
    .mode   (mode),
    .oe     (bus_oe)
  );

  xfer_qualify u_qual (
    .mode     (mode),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .ob_space (ob_space),
    .ib_avail (ib_avail),
    .fire     (fire)
  );

  strobe_stage #(.W(W), .DATA_RESET(1'b1)) u_stb (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .din    (bus_din),
    .q      (stb_q),
    .data_q (push_data)
  );

  assign push_valid = stb_q.push;
  assign pop_take   = stb_q.pop;
  assign bus_dout   = ib_head;
endmodule

// File: rtl/duplex_port_ctl_chk.sv
module duplex_port_ctl_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_n,
  input logic         dir_wr,
  input logic         wr_en,
  input logic         rd_en,
  input logic         ob_space,
  input logic         ib_avail,
  input logic [W-1:0] bus_din,
  input logic         push_valid,
  input logic [W-1:0] push_data,
  input logic         pop_take
);
  p_push_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> $past(!sel_n && dir_wr && wr_en && ob_space));

  p_push_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> push_data == $past(bus_din));

  p_pop_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_take |-> $past(!sel_n && !dir_wr && rd_en && ib_avail));

  p_pop_when_asked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !dir_wr && rd_en && ib_avail) |=> pop_take);

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (!push_valid && !pop_take));

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && pop_take));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid |-> $stable(push_data));
endmodule

bind duplex_port_ctl duplex_port_ctl_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_n      (sel_n),
  .dir_wr     (dir_wr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .ob_space   (ob_space),
  .ib_avail   (ib_avail),
  .bus_din    (bus_din),
  .push_valid (push_valid),
  .push_data  (push_data),
  .pop_take   (pop_take)
);

// File: tb/duplex_port_ctl_test.sv
`timescale 1ns/1ps
module duplex_port_ctl_test;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, dir_wr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic ob_space = 1'b0, ib_avail = 1'b0;
  logic [W-1:0] tb_drive = '0, ib_head = '0, pad;
  logic bus_oe, push_valid, pop_take;
  logic [W-1:0] bus_dout, push_data;

  int total = 0, bad = 0;
  logic [W-1:0] exp_data = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // Bench model of the shared pads: the port drives when enabled, else the host.
  always_comb pad = bus_oe ? bus_dout : tb_drive;

  duplex_port_ctl #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir_wr(dir_wr),
    .wr_en(wr_en), .rd_en(rd_en), .ob_space(ob_space), .ib_avail(ib_avail),
    .bus_din(pad), .ib_head(ib_head), .bus_oe(bus_oe), .bus_dout(bus_dout),
    .push_valid(push_valid), .push_data(push_data), .pop_take(pop_take)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_neg();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    // R6: reset state
    @(negedge clk);
    check("R6 push_valid in reset", W'(push_valid), '0);
    check("R6 pop_take in reset", W'(pop_take), '0);
    check("R6 push_data in reset", push_data, '0);
    sel_n = 1'b0; dir_wr = 1'b1; wr_en = 1'b1; ob_space = 1'b1; tb_drive = 18'h3ABCD;
    @(negedge clk);
    check("R6 no push while reset held", W'(push_valid), '0);
    sel_n = 1'b1; wr_en = 1'b0;
    rst_n = 1'b1;
    next_neg();
    check("R6 strobes low after reset", W'({push_valid, pop_take}), '0);
    check("R6 data zero after reset", push_data, '0);

    // Exhaustive sweep of the six control inputs, two passes
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 64; c++) begin
        logic e_push, e_pop, e_oe;
        logic [W-1:0] drv, head;
        sel_n    = c[0];
        dir_wr   = c[1];
        wr_en    = c[2];
        rd_en    = c[3];
        ob_space = c[4];
        ib_avail = c[5];
        drv  = W'((c + 64 * pass) * 2731) ^ 18'h2A5A5;
        head = W'((c + 64 * pass) * 777 + 5);
        tb_drive = drv;
        ib_head  = head;
        e_oe   = !c[0] && !c[1];
        e_push = !c[0] && c[1] && c[2] && c[4];
        e_pop  = !c[0] && !c[1] && c[3] && c[5];
        #1;
        check("R1 bus_oe decode", W'(bus_oe), W'(e_oe));
        check("R8 bus_dout is inbound head", bus_dout, head);
        next_neg();
        if (c[0]) check("R4 no strobe when deselected", W'({push_valid, pop_take}), '0);
        check("R2 push strobe", W'(push_valid), W'(e_push));
        check("R3 pop strobe", W'(pop_take), W'(e_pop));
        check("R5 strobes exclusive", W'(push_valid & pop_take), '0);
        if (e_push) exp_data = drv;
        if (e_push) check("R2 captured word", push_data, exp_data);
        else        check("R9 data held", push_data, exp_data);
        // return to idle and check nothing lingers
        sel_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        next_neg();
        check("R4 idle after sweep step", W'({push_valid, pop_take}), '0);
        check("R9 data held in idle", push_data, exp_data);
      end
    end

    // R7: selects toggled within a cycle with both enables low
    wr_en = 1'b0; rd_en = 1'b0; ob_space = 1'b1; ib_avail = 1'b1;
    for (int k = 0; k < 8; k++) begin
      sel_n = k[0]; dir_wr = k[1];
      #0.25;
      check("R7 oe follows selects mid-cycle", W'(bus_oe), W'(!k[0] && !k[1]));
    end
    sel_n = 1'b0; dir_wr = 1'b1;
    next_neg();
    check("R7 no transfer from select toggling", W'({push_valid, pop_take}), '0);
    check("R7 data unchanged", push_data, exp_data);

    // R3: read request with inbound FIFO empty, then back-to-back reads
    sel_n = 1'b0; dir_wr = 1'b0; rd_en = 1'b1; ib_avail = 1'b0;
    next_neg();
    check("R3 pop suppressed when empty", W'(pop_take), '0);
    ib_avail = 1'b1;
    next_neg();
    check("R3 pop on first available", W'(pop_take), 1);
    next_neg();
    check("R3 pop back-to-back", W'(pop_take), 1);
    // R5: turn around directly from read to write
    dir_wr = 1'b1; wr_en = 1'b1; tb_drive = 18'h15A5A;
    next_neg();
    check("R5 no overlap at turnaround", W'(push_valid & pop_take), '0);
    check("R2 push after turnaround", W'(push_valid), 1);
    check("R2 word after turnaround", push_data, 18'h15A5A);
    sel_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    next_neg();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule